// File: doc/BRIEF.md
# Coprocessor Bank Address Decoder

This block sits on the address path of a coprocessor bus. Each request carries a 24-bit address: an 8-bit bank and a 16-bit offset within that bank. The block works out which target the address belongs to. The targets are a 2 KiB work RAM, a small register window, cartridge backup RAM, a packed-pixel view of backup RAM, and program ROM. Any address outside these falls into unmapped space. For the chosen target the block also computes a linear local offset. That offset is masked to the target's configured size, so a smaller memory repeats across its window.

The low bank halves (0x00–0x3F and 0x80–0xBF) mirror each other. Each half is split into windows, with holes between them. Reads from a hole return the byte that was last seen on the data bus. Writes to a hole go nowhere.

A mode input selects a second decode personality. It serves a side reader that fetches variable-length data. In that mode the register window and the packed-pixel view both count as unmapped, so the side reader can never reach a register. The full-bank backup RAM range stays visible in both modes.

Top module: `cpbus_bank_decoder`

## Requirements
- R1: In banks 0x00–0x3F and 0x80–0xBF, offsets 0x0000–0x07FF and 0x3000–0x37FF select work RAM (rsp_sel bit 0), with local offset equal to address bits [10:0].
- R2: In those banks, offsets 0x2200–0x23FF select the register window (bit 1) with offset = address − 0x2200 when side_mode is 0. When side_mode is 1, the same range is unmapped.
- R3: In those banks, offsets 0x6000–0x7FFF select backup RAM (bit 2) with offset ((bank & 0x3F) × 0x2000 + offset − 0x6000), masked to BRAM_AW bits.
- R4: In those banks, offsets 0x8000–0xFFFF select program ROM (bit 4) with offset ((bank & 0x3F) × 0x8000 + offset − 0x8000), masked to ROM_AW bits.
- R5: Banks 0x40–0x4F select backup RAM in both modes, with offset ((bank − 0x40) × 0x10000 + offset), masked to BRAM_AW bits.
- R6: Banks 0xC0–0xFF select program ROM, with offset ((bank − 0xC0) × 0x10000 + offset), masked to ROM_AW bits.
- R7: Banks 0x60–0x6F select the packed-pixel view (bit 3) when side_mode is 0, with offset ((bank − 0x60) × 0x10000 + offset), masked to PIX_AW bits. When side_mode is 1 these banks are unmapped.
- R8: Every other address is unmapped. Such an address sets bit 5 with offset 0, and rsp_we stays 0 even for a write. For mapped targets, rsp_we follows req_write.
- R9: The response is registered. The cycle after req_valid, rsp_valid is 1 and rsp_sel is one-hot. In a cycle with no response, rsp_sel is all zero.
- R10: During a read response, rsp_rdata equals mem_rdata for a mapped target and equals the held open-bus byte for an unmapped target.
- R11: The open-bus byte is loaded at every response cycle. A write loads rsp_wdata and a read loads rsp_rdata.
- R12: After reset, rsp_valid is 0, rsp_sel is 0 and the open-bus byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_addr | input | 24 | Bank in [23:16], offset in [15:0] |
| req_write | input | 1 | 1 for a write access |
| req_wdata | input | 8 | Write data |
| side_mode | input | 1 | 1 selects the side-reader decode personality |
| mem_rdata | input | 8 | Read data from the selected target during the response cycle |
| rsp_valid | output | 1 | Response cycle marker |
| rsp_sel | output | 6 | One-hot target: 0 work RAM, 1 registers, 2 backup RAM, 3 pixel view, 4 ROM, 5 unmapped |
| rsp_off | output | 24 | Masked local offset within the target |
| rsp_we | output | 1 | Write enable toward a mapped target |
| rsp_wdata | output | 8 | Registered write data |
| rsp_rdata | output | 8 | Read data returned to the requester |

## Verification
The bench sweeps every window edge in both bank halves and in both modes, and crosses them with random addresses. Three kinds of error are targeted:
- A decoder whose off-by-one compare is wrong would move the edge of a hole, such as 0x0800, 0x21FF, 0x2400 or 0x3800, into a neighbouring target.
- A decoder that ignores side_mode would let the side reader reach the registers.
- A decoder that linearises banks wrongly would give the wrong offset for bank 0xBF or 0xC0, or for a small ROM that must mirror.

Open-bus behaviour is checked as well. The bench interleaves writes and reads to holes, and expects each unmapped read to return the previous transfer's byte. It also expects an unmapped write to leave rsp_we low.

// File: rtl/cobd_pkg.sv
package cobd_pkg;
  typedef enum logic [2:0] {
    TGT_IRAM = 3'd0,
    TGT_REGS = 3'd1,
    TGT_BRAM = 3'd2,
    TGT_PIX  = 3'd3,
    TGT_ROM  = 3'd4,
    TGT_NONE = 3'd5
  } cobd_tgt_e;

  localparam int NUM_TGT  = 6;
  localparam int TBL_SIZE = 8;
  localparam int ADDR_W   = 24;
endpackage

// File: rtl/cobd_region_decode.sv
module cobd_region_decode
  import cobd_pkg::*;
(
  input  logic [7:0]        bank,
  input  logic [15:0]       offs,
  input  logic              side_mode,
  output cobd_tgt_e         tgt,
  output logic [ADDR_W-1:0] lin
);
  logic sys_bank;
  logic in_iram, in_regs, in_bram_lo, in_rom_lo;

  // 0x00-0x3F and 0x80-0xBF share one layout (bit 6 clear)
  assign sys_bank   = ~bank[6];
  assign in_rom_lo  = offs[15];
  assign in_bram_lo = (offs[15:13] == 3'b011);
  assign in_iram    = (offs[15:11] == 5'b00000) || (offs[15:11] == 5'b00110);
  assign in_regs    = (offs[15:9] == 7'b0010001);

  always_comb begin
    tgt = TGT_NONE;
    lin = '0;
    if (sys_bank) begin
      if (in_rom_lo) begin
        tgt = TGT_ROM;
        lin = {3'b0, bank[5:0], offs[14:0]};
      end else if (in_bram_lo) begin
        tgt = TGT_BRAM;
        lin = {5'b0, bank[5:0], offs[12:0]};
      end else if (in_iram) begin
        tgt = TGT_IRAM;
        lin = {13'b0, offs[10:0]};
      end else if (in_regs && !side_mode) begin
        tgt = TGT_REGS;
        lin = {15'b0, offs[8:0]};
      end
    end else if (bank[7:4] == 4'h4) begin
      tgt = TGT_BRAM;
      lin = {4'b0, bank[3:0], offs};
    end else if (bank[7:4] == 4'h6 && !side_mode) begin
      tgt = TGT_PIX;
      lin = {4'b0, bank[3:0], offs};
    end else if (bank[7:6] == 2'b11) begin
      tgt = TGT_ROM;
      lin = {2'b0, bank[5:0], offs};
    end
  end
endmodule

// File: rtl/cobd_offset_mask.sv
module cobd_offset_mask
  import cobd_pkg::*;
#(
  parameter int IRAM_AW = 11,
  parameter int REGS_AW = 9,
  parameter int BRAM_AW = 18,
  parameter int PIX_AW  = 20,
  parameter int ROM_AW  = 22
) (
  input  cobd_tgt_e         tgt,
  input  logic [ADDR_W-1:0] lin,
  output logic [ADDR_W-1:0] off
);
  logic [ADDR_W-1:0] mask_tbl [TBL_SIZE];

  for (genvar g = 0; g < TBL_SIZE; g++) begin : g_mask
    localparam int AW = (g == 0) ? IRAM_AW :
                        (g == 1) ? REGS_AW :
                        (g == 2) ? BRAM_AW :
                        (g == 3) ? PIX_AW  :
                        (g == 4) ? ROM_AW  : 0;
    localparam logic [63:0] FULL = (64'd1 << AW) - 64'd1;
    assign mask_tbl[g] = FULL[ADDR_W-1:0];
  end

  assign off = lin & mask_tbl[tgt];
endmodule

// File: rtl/cobd_open_bus.sv
module cobd_open_bus (
  input  logic       clk,
  input  logic       rst,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 8'h00;
    else if (upd) q <= din;
  end
endmodule

// File: rtl/cpbus_bank_decoder.sv
module cpbus_bank_decoder
  import cobd_pkg::*;
#(
  parameter int IRAM_AW = 11,
  parameter int REGS_AW = 9,
  parameter int BRAM_AW = 18,
  parameter int PIX_AW  = 20,
  parameter int ROM_AW  = 22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  input  logic [7:0]         req_wdata,
  input  logic               side_mode,
  input  logic [7:0]         mem_rdata,
  output logic               rsp_valid,
  output logic [NUM_TGT-1:0] rsp_sel,
  output logic [ADDR_W-1:0]  rsp_off,
  output logic               rsp_we,
  output logic [7:0]         rsp_wdata,
  output logic [7:0]         rsp_rdata
);
  cobd_tgt_e          tgt_d;
  logic [ADDR_W-1:0]  lin_d, off_d;
  logic [NUM_TGT-1:0] sel_d;
  logic               rsp_wr_q;
  logic [7:0]         ob_q, ob_din;

  cobd_region_decode u_dec (
    .bank      (req_addr[23:16]),
    .offs      (req_addr[15:0]),
    .side_mode (side_mode),
    .tgt       (tgt_d),
    .lin       (lin_d)
  );

  cobd_offset_mask #(
    .IRAM_AW(IRAM_AW), .REGS_AW(REGS_AW), .BRAM_AW(BRAM_AW),
    .PIX_AW(PIX_AW), .ROM_AW(ROM_AW)
  ) u_mask (
    .tgt (tgt_d),
    .lin (lin_d),
    .off (off_d)
  );

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
    assign sel_d[g] = (tgt_d == cobd_tgt_e'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_sel   <= '0;
      rsp_off   <= '0;
      rsp_we    <= 1'b0;
      rsp_wr_q  <= 1'b0;
      rsp_wdata <= 8'h00;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_sel   <= sel_d;
        rsp_off   <= off_d;
        rsp_we    <= req_write && (tgt_d != TGT_NONE);
        rsp_wr_q  <= req_write;
        rsp_wdata <= req_wdata;
      end else begin
        rsp_sel   <= '0;
        rsp_we    <= 1'b0;
        rsp_wr_q  <= 1'b0;
      end
    end
  end

  assign rsp_rdata = rsp_sel[TGT_NONE] ? ob_q : mem_rdata;
  assign ob_din    = rsp_wr_q ? rsp_wdata : rsp_rdata;

  cobd_open_bus u_ob (
    .clk (clk),
    .rst (rst),
    .upd (rsp_valid),
    .din (ob_din),
    .q   (ob_q)
  );
endmodule

// File: rtl/cobd_checker.sv
module cobd_checker #(
  parameter int IRAM_AW = 11
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        side_mode,
  input logic        rsp_valid,
  input logic [5:0]  rsp_sel,
  input logic [23:0] rsp_off,
  input logic        rsp_we
);
  AST_RST_IDLE: assert property (@(posedge clk)
    rst |=> (!rsp_valid && rsp_sel == 6'b0)); // R12

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones(rsp_sel) == 1); // R9

  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> rsp_sel == 6'b0); // R9

  AST_SIDE_NO_REGS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && side_mode) |=> (!rsp_sel[1] && !rsp_sel[3])); // R2 R7

  AST_UNMAPPED_NO_WE: assert property (@(posedge clk) disable iff (rst)
    rsp_sel[5] |-> !rsp_we); // R8

  AST_IRAM_OFF_RANGE: assert property (@(posedge clk) disable iff (rst)
    rsp_sel[0] |-> (rsp_off >> IRAM_AW) == 24'd0); // R1
endmodule

bind cpbus_bank_decoder cobd_checker #(.IRAM_AW(IRAM_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .side_mode (side_mode),
  .rsp_valid (rsp_valid),
  .rsp_sel   (rsp_sel),
  .rsp_off   (rsp_off),
  .rsp_we    (rsp_we)
);

// File: tb/tb_cpbus_bank_decoder.sv
`timescale 1ns/1ps
module tb_cpbus_bank_decoder;
  localparam int IRAM_AW = 11, REGS_AW = 9, BRAM_AW = 18, PIX_AW = 20, ROM_AW = 22;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        side_mode = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        rsp_valid, rsp_we;
  logic [5:0]  rsp_sel;
  logic [23:0] rsp_off;
  logic [7:0]  rsp_wdata, rsp_rdata;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] ob_m = 8'h00;

  always #10 clk = ~clk;

  cpbus_bank_decoder #(
    .IRAM_AW(IRAM_AW), .REGS_AW(REGS_AW), .BRAM_AW(BRAM_AW),
    .PIX_AW(PIX_AW), .ROM_AW(ROM_AW)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .side_mode(side_mode),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_sel(rsp_sel),
    .rsp_off(rsp_off), .rsp_we(rsp_we), .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Reference decode: target index 0..5 and masked local offset
  function automatic void model(input logic [23:0] a, input bit side,
                                output int t, output longint off);
    int b, o, aw;
    b = int'(a[23:16]);
    o = int'(a[15:0]);
    t = 5; off = 0;
    if (b < 'h40 || (b >= 'h80 && b < 'hC0)) begin
      if (o >= 'h8000) begin t = 4; off = (b % 'h40) * 'h8000 + (o - 'h8000); end
      else if (o >= 'h6000) begin t = 2; off = (b % 'h40) * 'h2000 + (o - 'h6000); end
      else if (o < 'h800) begin t = 0; off = o; end
      else if (o >= 'h3000 && o < 'h3800) begin t = 0; off = o - 'h3000; end
      else if (o >= 'h2200 && o < 'h2400 && !side) begin t = 1; off = o - 'h2200; end
    end else if (b >= 'h40 && b < 'h50) begin t = 2; off = (b - 'h40) * 'h10000 + o; end
    else if (b >= 'h60 && b < 'h70 && !side) begin t = 3; off = (b - 'h60) * 'h10000 + o; end
    else if (b >= 'hC0) begin t = 4; off = (b - 'hC0) * 'h10000 + o; end
    case (t)
      0: aw = IRAM_AW; 1: aw = REGS_AW; 2: aw = BRAM_AW;
      3: aw = PIX_AW;  4: aw = ROM_AW;  default: aw = 0;
    endcase
    off = off % (longint'(1) << aw);
    if (t == 5) off = 0;
  endfunction

  function automatic string req_of(input int t, input logic [23:0] a);
    int b;
    b = int'(a[23:16]);
    case (t)
      0: return "R1";
      1: return "R2";
      2: return (b >= 'h40 && b < 'h50) ? "R5" : "R3";
      3: return "R7";
      4: return (b >= 'hC0) ? "R6" : "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic txn(input logic [23:0] a, input bit wr, input logic [7:0] wd, input bit side);
    int t; longint off; logic [7:0] exp_rd; string rq;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd; side_mode = side;
    @(negedge clk);
    req_valid = 1'b0; mem_rdata = 8'($urandom);
    #1;
    model(a, side, t, off);
    rq = req_of(t, a);
    chk(rsp_valid == 1'b1, "R9 valid", rsp_valid, 1);
    chk(rsp_sel == 6'(1 << t), {rq, " sel"}, rsp_sel, 1 << t);
    chk(longint'(rsp_off) == off, {rq, " off"}, rsp_off, off);
    chk(rsp_we == (wr && t != 5), "R8 we", rsp_we, wr && t != 5);
    if (wr) begin
      ob_m = wd;
    end else begin
      exp_rd = (t == 5) ? ob_m : mem_rdata;
      chk(rsp_rdata == exp_rd, (t == 5) ? "R10 R11 openbus" : "R10 mapped", rsp_rdata, exp_rd);
      ob_m = exp_rd;
    end
  endtask

  logic [15:0] edge_off [15] = '{16'h0000, 16'h07FF, 16'h0800, 16'h21FF, 16'h2200,
                                 16'h23FF, 16'h2400, 16'h2FFF, 16'h3000, 16'h37FF,
                                 16'h3800, 16'h5FFF, 16'h6000, 16'h7FFF, 16'h8000};
  logic [7:0]  edge_bank [14] = '{8'h00, 8'h3F, 8'h40, 8'h4F, 8'h50, 8'h5F, 8'h60,
                                  8'h6F, 8'h70, 8'h7F, 8'h80, 8'hBF, 8'hC0, 8'hFF};

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(rsp_valid == 1'b0, "R12 valid", rsp_valid, 0);
    chk(rsp_sel == 6'b0, "R12 sel", rsp_sel, 0);
    // unmapped read right after reset must return 0x00
    txn(24'h50_1234, 1'b0, 8'h00, 1'b0);
    chk(rsp_rdata == 8'h00 || ob_m == 8'h00, "R12 openbus", rsp_rdata, 0);
    @(negedge clk); #1;
    chk(rsp_sel == 6'b0 && !rsp_valid, "R9 idle", rsp_sel, 0);

    // open-bus: write to a hole, then read a hole
    txn(24'h00_1000, 1'b1, 8'hA5, 1'b0);
    txn(24'h00_2500, 1'b0, 8'h00, 1'b0);
    chk(rsp_rdata == 8'hA5, "R11 hole write then read", rsp_rdata, 8'hA5);
    txn(24'h80_2200, 1'b0, 8'h00, 1'b1); // side-mode register window is unmapped (R2)
    txn(24'hFF_FFFF, 1'b1, 8'h3C, 1'b0);

    // directed window edges in both modes
    for (int s = 0; s < 2; s++)
      for (int bi = 0; bi < 14; bi++)
        for (int oi = 0; oi < 15; oi++) begin
          txn({edge_bank[bi], edge_off[oi]}, 1'b0, 8'h00, bit'(s));
          txn({edge_bank[bi], 16'hFFFF - 16'(oi)}, 1'b1, 8'($urandom), bit'(s));
        end

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [23:0] a;
      a = 24'($urandom);
      if (($urandom % 4) == 0) a[15:0] = edge_off[$urandom % 15];
      txn(a, bit'($urandom % 3 == 0), 8'($urandom), bit'($urandom % 2));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule